// File: doc/BRIEF.md
# Circle Hough Transform Accumulator

This block locates the single strongest circle in a small binary edge image by voting. A start pulse captures the edge bitmap and a rectangular search window into on-chip registers. The sequencer first clears the vote memory, then walks every pixel of the image. For each pixel that is an edge, it visits a fixed set of points on the circles of every candidate radius around that pixel. A visited point earns one vote, at that point's own position and for that radius, only when it is itself an edge and lies inside both the image and the window.

After voting, the block scans the whole vote memory once and keeps the entry with the most votes. It then pulses `done_o` and reports the centre, the radius and the vote count. A first pass normally uses a window covering the whole image. A second pass can then be confined to a box inside the circle found by the first pass, which is how an inner boundary is searched within an outer one.

Top module: `hough_circle_finder`

## Requirements
- R1: While reset is held and after its release, `done_o` is 0 and `cx_o`, `cy_o`, `radius_o` and `votes_o` are all 0.
- R2: `start_i` is only accepted when no pass is running, and a pulse during a pass is ignored. Each accepted pass ends with `done_o` high for exactly one cycle. The results change only in that cycle and then hold until the next pass completes.
- R3: Radius index i stands for the radius r = R_MIN + i*R_STEP. With a = (r*181+128)/256 (integer division), the eight circle points of that radius lie at offsets (+r,0), (-r,0), (0,+r), (0,-r), (+a,+a), (-a,+a), (+a,-a) and (-a,-a) from the edge pixel.
- R4: A sweep starts only from a pixel whose bit is 1 in `edge_map_i` (bit index y*IMG_W+x). A point earns a vote only when its own bit is also 1, so an isolated edge pixel produces no votes.
- R5: Points outside the image or outside the inclusive window [`win_x_lo_i`..`win_x_hi_i`] x [`win_y_lo_i`..`win_y_hi_i`] earn no vote. The window is captured at start.
- R6: The vote memory is cleared at the start of every pass, so no votes carry over from an earlier pass.
- R7: Each vote counter saturates at 2^CNT_W-1 and never wraps.
- R8: The reported entry holds the maximum vote count. On a tie, the first entry in scan order is kept: radius index outermost, then row, then column, all ascending. `radius_o` gives the radius value, not the index.
- R9: If no vote is cast, the result is centre (0,0), radius R_MIN and a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a pass when idle |
| edge_map_i | input | IMG_W*IMG_H | Binary edge bitmap, bit y*IMG_W+x |
| win_x_lo_i | input | XW | Window left column, inclusive |
| win_x_hi_i | input | XW | Window right column, inclusive |
| win_y_lo_i | input | YW | Window top row, inclusive |
| win_y_hi_i | input | YW | Window bottom row, inclusive |
| done_o | output | 1 | One-cycle pulse when the results are valid |
| cx_o | output | XW | Centre column of the best entry |
| cy_o | output | YW | Centre row of the best entry |
| radius_o | output | RADW | Radius of the best entry |
| votes_o | output | CNT_W | Vote count of the best entry |

## Verification
The bench builds an 8x8 image with two radii (1 and 2) and 3-bit counters. With this configuration a filled interior neighbourhood of eight votes overflows the counter, so saturation can be reached. The r=2 diagonal collapses onto the r=1 diagonal, which checks the offset rounding. Each pass takes only a few hundred cycles, so many passes fit in one run. Each pass is compared with a bench model that recounts every centre and radius and then picks the maximum in scan order. The bench runs directed maps (empty, single pixel, two pixels, full, and tied maps) together with random maps under random windows.

// File: rtl/hough_pkg.sv
package hough_pkg;
  localparam int NUM_PTS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_VOTE,
    ST_PEAK,
    ST_FIN
  } hough_st_e;
endpackage

// File: rtl/hough_offset_rom.sv
module hough_offset_rom #(
  parameter int NUM_RAD = 4,
  parameter int R_MIN   = 2,
  parameter int R_STEP  = 2,
  parameter int RIW     = 2,
  parameter int CW      = 7
) (
  input  logic [RIW-1:0]       ri_i,
  input  logic [2:0]           pt_i,
  output logic signed [CW-1:0] dx_o,
  output logic signed [CW-1:0] dy_o
);
  logic signed [CW-1:0] r_tab [NUM_RAD];
  logic signed [CW-1:0] a_tab [NUM_RAD];

  for (genvar gi = 0; gi < NUM_RAD; gi++) begin : g_rad
    localparam int RV = R_MIN + gi * R_STEP;
    localparam int AV = (RV * 181 + 128) / 256;
    assign r_tab[gi] = CW'(RV);
    assign a_tab[gi] = CW'(AV);
  end

  logic signed [CW-1:0] r_v, a_v;
  assign r_v = r_tab[ri_i];
  assign a_v = a_tab[ri_i];

  always_comb begin
    unique case (pt_i)
      3'd0:    begin dx_o =  r_v; dy_o = '0;   end
      3'd1:    begin dx_o = -r_v; dy_o = '0;   end
      3'd2:    begin dx_o = '0;   dy_o =  r_v; end
      3'd3:    begin dx_o = '0;   dy_o = -r_v; end
      3'd4:    begin dx_o =  a_v; dy_o =  a_v; end
      3'd5:    begin dx_o = -a_v; dy_o =  a_v; end
      3'd6:    begin dx_o =  a_v; dy_o = -a_v; end
      default: begin dx_o = -a_v; dy_o = -a_v; end
    endcase
  end
endmodule

// File: rtl/hough_acc_mem.sv
module hough_acc_mem #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [AW-1:0]    addr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] acc_q [DEPTH];
  logic [CNT_W-1:0] nxt;

  assign cnt_o = acc_q[addr_i];
  assign nxt   = (cnt_o == '1) ? cnt_o : cnt_o + 1'b1;

  always_ff @(posedge clk_i) begin
    if (clr_i)      acc_q[addr_i] <= '0;
    else if (inc_i) acc_q[addr_i] <= nxt;
  end

  // R7
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (acc_q[$past(addr_i)] != '0));
endmodule

// File: rtl/hough_peak.sv
module hough_peak #(
  parameter int XW    = 4,
  parameter int YW    = 4,
  parameter int RIW   = 2,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             scan_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [XW-1:0]    x_i,
  input  logic [YW-1:0]    y_i,
  input  logic [RIW-1:0]   r_i,
  output logic [CNT_W-1:0] best_cnt_o,
  output logic [XW-1:0]    best_x_o,
  output logic [YW-1:0]    best_y_o,
  output logic [RIW-1:0]   best_r_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_cnt_o <= '0;
      best_x_o   <= '0;
      best_y_o   <= '0;
      best_r_o   <= '0;
    end else if (init_i) begin
      best_cnt_o <= '0;
      best_x_o   <= '0;
      best_y_o   <= '0;
      best_r_o   <= '0;
    end else if (scan_i && cnt_i > best_cnt_o) begin
      // strict compare keeps the earliest entry on a tie
      best_cnt_o <= cnt_i;
      best_x_o   <= x_i;
      best_y_o   <= y_i;
      best_r_o   <= r_i;
    end
  end

  // R8
  peak_ge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_i && !init_i) |=> (best_cnt_o >= $past(cnt_i)));
  // R8
  peak_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_i && !init_i) |=> (best_cnt_o >= $past(best_cnt_o)));
endmodule

// File: rtl/hough_circle_finder.sv
module hough_circle_finder
  import hough_pkg::*;
#(
  parameter int IMG_W   = 16,
  parameter int IMG_H   = 16,
  parameter int NUM_RAD = 4,
  parameter int R_MIN   = 2,
  parameter int R_STEP  = 2,
  parameter int CNT_W   = 5,
  localparam int XW     = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int YW     = (IMG_H > 1) ? $clog2(IMG_H) : 1,
  localparam int R_MAX  = R_MIN + (NUM_RAD - 1) * R_STEP,
  localparam int RADW   = $clog2(R_MAX + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [IMG_W*IMG_H-1:0] edge_map_i,
  input  logic [XW-1:0]          win_x_lo_i,
  input  logic [XW-1:0]          win_x_hi_i,
  input  logic [YW-1:0]          win_y_lo_i,
  input  logic [YW-1:0]          win_y_hi_i,
  output logic                   done_o,
  output logic [XW-1:0]          cx_o,
  output logic [YW-1:0]          cy_o,
  output logic [RADW-1:0]        radius_o,
  output logic [CNT_W-1:0]       votes_o
);
  localparam int RIW   = (NUM_RAD > 1) ? $clog2(NUM_RAD) : 1;
  localparam int MW    = (XW > YW) ? XW : YW;
  localparam int CW    = ((MW > RADW) ? MW : RADW) + 2;
  localparam int NPIX  = IMG_W * IMG_H;
  localparam int DEPTH = NPIX * NUM_RAD;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  hough_st_e          st_q;
  logic [NPIX-1:0]    map_q;
  logic [XW-1:0]      wxl_q, wxh_q;
  logic [YW-1:0]      wyl_q, wyh_q;
  logic [XW-1:0]      x_q;
  logic [YW-1:0]      y_q;
  logic [RIW-1:0]     r_q;
  logic [2:0]         pt_q;
  logic               done_q;

  logic last_x, last_y, last_r, last_pt, scan_last;
  assign last_x    = (x_q == XW'(IMG_W - 1));
  assign last_y    = (y_q == YW'(IMG_H - 1));
  assign last_r    = (r_q == RIW'(NUM_RAD - 1));
  assign last_pt   = (pt_q == 3'(NUM_PTS - 1));
  assign scan_last = last_x && last_y && last_r;

  logic start_ok;
  assign start_ok = (st_q == ST_IDLE) && start_i;

  // current pixel
  logic [AW-1:0] pix_idx, r_base;
  logic          cur_edge;
  assign pix_idx  = AW'(y_q) * AW'(IMG_W) + AW'(x_q);
  assign r_base   = AW'(r_q) * AW'(NPIX);
  assign cur_edge = map_q[pix_idx];

  // circle point
  logic signed [CW-1:0] dx, dy, qx_s, qy_s;
  hough_offset_rom #(
    .NUM_RAD(NUM_RAD), .R_MIN(R_MIN), .R_STEP(R_STEP), .RIW(RIW), .CW(CW)
  ) u_rom (
    .ri_i(r_q), .pt_i(pt_q), .dx_o(dx), .dy_o(dy)
  );

  assign qx_s = $signed({{(CW-XW){1'b0}}, x_q}) + dx;
  assign qy_s = $signed({{(CW-YW){1'b0}}, y_q}) + dy;

  logic q_ok, q_edge, vote_inc;
  logic [AW-1:0] q_idx;
  assign q_ok = (qx_s >= 0) && (qx_s < $signed(CW'(IMG_W))) &&
                (qy_s >= 0) && (qy_s < $signed(CW'(IMG_H))) &&
                (qx_s >= $signed({{(CW-XW){1'b0}}, wxl_q})) &&
                (qx_s <= $signed({{(CW-XW){1'b0}}, wxh_q})) &&
                (qy_s >= $signed({{(CW-YW){1'b0}}, wyl_q})) &&
                (qy_s <= $signed({{(CW-YW){1'b0}}, wyh_q}));
  assign q_idx    = AW'(qy_s[YW-1:0]) * AW'(IMG_W) + AW'(qx_s[XW-1:0]);
  assign q_edge   = q_ok && map_q[q_idx];
  assign vote_inc = (st_q == ST_VOTE) && cur_edge && q_edge;

  // vote memory
  logic [AW-1:0]    mem_addr;
  logic [CNT_W-1:0] mem_cnt;
  assign mem_addr = r_base + ((st_q == ST_VOTE) ? q_idx : pix_idx);

  hough_acc_mem #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_mem (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_q == ST_CLEAR),
    .inc_i (vote_inc),
    .addr_i(mem_addr),
    .cnt_o (mem_cnt)
  );

  // maximum tracking
  logic [CNT_W-1:0] best_cnt;
  logic [XW-1:0]    best_x;
  logic [YW-1:0]    best_y;
  logic [RIW-1:0]   best_r;

  hough_peak #(.XW(XW), .YW(YW), .RIW(RIW), .CNT_W(CNT_W)) u_peak (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (start_ok),
    .scan_i    (st_q == ST_PEAK),
    .cnt_i     (mem_cnt),
    .x_i       (x_q),
    .y_i       (y_q),
    .r_i       (r_q),
    .best_cnt_o(best_cnt),
    .best_x_o  (best_x),
    .best_y_o  (best_y),
    .best_r_o  (best_r)
  );

  // sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      map_q    <= '0;
      wxl_q    <= '0;
      wxh_q    <= '0;
      wyl_q    <= '0;
      wyh_q    <= '0;
      x_q      <= '0;
      y_q      <= '0;
      r_q      <= '0;
      pt_q     <= '0;
      done_q   <= 1'b0;
      cx_o     <= '0;
      cy_o     <= '0;
      radius_o <= '0;
      votes_o  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          map_q <= edge_map_i;
          wxl_q <= win_x_lo_i;
          wxh_q <= win_x_hi_i;
          wyl_q <= win_y_lo_i;
          wyh_q <= win_y_hi_i;
          x_q   <= '0;
          y_q   <= '0;
          r_q   <= '0;
          pt_q  <= '0;
          st_q  <= ST_CLEAR;
        end
        ST_CLEAR, ST_PEAK: begin
          // scan order: column, row, radius
          if (last_x) begin
            x_q <= '0;
            if (last_y) begin
              y_q <= '0;
              r_q <= last_r ? '0 : r_q + 1'b1;
            end else begin
              y_q <= y_q + 1'b1;
            end
          end else begin
            x_q <= x_q + 1'b1;
          end
          if (scan_last) st_q <= (st_q == ST_CLEAR) ? ST_VOTE : ST_FIN;
        end
        ST_VOTE: begin
          if (!cur_edge || (last_r && last_pt)) begin
            r_q  <= '0;
            pt_q <= '0;
            if (last_x) begin
              x_q <= '0;
              if (last_y) begin
                y_q  <= '0;
                st_q <= ST_PEAK;
              end else begin
                y_q <= y_q + 1'b1;
              end
            end else begin
              x_q <= x_q + 1'b1;
            end
          end else if (last_pt) begin
            pt_q <= '0;
            r_q  <= r_q + 1'b1;
          end else begin
            pt_q <= pt_q + 1'b1;
          end
        end
        ST_FIN: begin
          cx_o     <= best_x;
          cy_o     <= best_y;
          radius_o <= RADW'(R_MIN) + RADW'(best_r) * RADW'(R_STEP);
          votes_o  <= best_cnt;
          done_q   <= 1'b1;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  result_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(votes_o) || !$stable(cx_o) || !$stable(cy_o) || !$stable(radius_o))
      |-> done_o);
endmodule

// File: tb/hough_circle_finder_tb.sv
module hough_circle_finder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int H = 8;
  localparam int NR = 2;
  localparam int RMIN = 1;
  localparam int RSTEP = 1;
  localparam int CNTW = 3;
  localparam int SAT = (1 << CNTW) - 1;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W*H-1:0] emap = '0;
  logic [2:0] wxl = '0, wxh = 3'd7, wyl = '0, wyh = 3'd7;
  logic done;
  logic [2:0] cx, cy;
  logic [1:0] rad;
  logic [CNTW-1:0] votes;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hough_circle_finder #(
    .IMG_W(W), .IMG_H(H), .NUM_RAD(NR), .R_MIN(RMIN), .R_STEP(RSTEP), .CNT_W(CNTW)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .edge_map_i(emap),
    .win_x_lo_i(wxl), .win_x_hi_i(wxh), .win_y_lo_i(wyl), .win_y_hi_i(wyh),
    .done_o(done), .cx_o(cx), .cy_o(cy), .radius_o(rad), .votes_o(votes)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit is_edge(input int x, input int y);
    if (x < 0 || x >= W || y < 0 || y >= H) return 0;
    return emap[y*W + x];
  endfunction

  // R3 offset table
  function automatic void offs(input int ri, input int pt, output int dx, output int dy);
    int r, a;
    r = RMIN + ri * RSTEP;
    a = (r * 181 + 128) / 256;
    case (pt)
      0: begin dx =  r; dy =  0; end
      1: begin dx = -r; dy =  0; end
      2: begin dx =  0; dy =  r; end
      3: begin dx =  0; dy = -r; end
      4: begin dx =  a; dy =  a; end
      5: begin dx = -a; dy =  a; end
      6: begin dx =  a; dy = -a; end
      default: begin dx = -a; dy = -a; end
    endcase
  endfunction

  function automatic int model_acc(input int ri, input int x, input int y);
    int n, dx, dy;
    n = 0;
    if (x < wxl || x > wxh || y < wyl || y > wyh || !is_edge(x, y)) return 0;
    for (int pt = 0; pt < 8; pt++) begin
      offs(ri, pt, dx, dy);
      if (is_edge(x - dx, y - dy)) n++;
    end
    return (n > SAT) ? SAT : n;
  endfunction

  int ex_x, ex_y, ex_r, ex_v;
  function automatic void model_peak();
    int c;
    ex_x = 0; ex_y = 0; ex_r = RMIN; ex_v = 0;
    for (int ri = 0; ri < NR; ri++)
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++) begin
          c = model_acc(ri, x, y);
          if (c > ex_v) begin
            ex_v = c; ex_x = x; ex_y = y; ex_r = RMIN + ri * RSTEP;
          end
        end
  endfunction

  task automatic wait_done(output bit got);
    int n;
    n = 0;
    while (!done && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
    got = done;
    if (!got) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual 0 expected 1 (no done)");
    end
  endtask

  task automatic run_pass(input string req);
    bit got;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(got);
    if (got) begin
      model_peak();
      chk({req, " cx"}, cx, ex_x);
      chk({req, " cy"}, cy, ex_y);
      chk({req, " radius"}, rad, ex_r);
      chk({req, " votes"}, votes, ex_v);
      @(negedge clk);
      chk("R2 done one cycle", done, 0);
    end
  endtask

  task automatic set_pix(input int x, input int y);
    emap[y*W + x] = 1'b1;
  endtask

  task automatic full_win();
    wxl = 0; wxh = 7; wyl = 0; wyh = 7;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int dones;
    bit got;
    logic [W*H-1:0] keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", done, 0);
    chk("R1 cx", cx, 0);
    chk("R1 votes", votes, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 radius", rad, 0);
    chk("R1 cy", cy, 0);

    // R9 empty map
    emap = '0; full_win();
    run_pass("R9");
    chk("R9 radius is R_MIN", rad, RMIN);

    // R4 isolated edge pixel casts no vote
    emap = '0; set_pix(3, 3);
    run_pass("R4");
    chk("R4 no votes", votes, 0);

    // R3 two pixels two apart: only radius 2 links them
    emap = '0; set_pix(2, 2); set_pix(4, 2);
    run_pass("R3");
    chk("R3 radius 2", rad, 2);
    chk("R3 votes 1", votes, 1);

    // R3 diagonal neighbours: r=1 and r=2 share diagonal (a=1); tie keeps r=1
    emap = '0; set_pix(2, 2); set_pix(3, 3);
    run_pass("R8 tie");
    chk("R8 tie first x", cx, 2);
    chk("R8 tie first radius", rad, 1);

    // R7 full map saturates, first reach at (1,1) radius 1
    emap = '1; full_win();
    run_pass("R7");
    chk("R7 saturated", votes, SAT);
    chk("R7 x", cx, 1);
    chk("R7 y", cy, 1);

    // R6 empty map after full map: nothing carried over
    emap = '0;
    run_pass("R6");
    chk("R6 votes cleared", votes, 0);

    // R5 window restrictions
    emap = '1; wxl = 0; wxh = 0; wyl = 0; wyh = 0;
    run_pass("R5");
    chk("R5 corner votes", votes, 3);
    wxl = 4; wxh = 5; wyl = 4; wyh = 5;
    run_pass("R5");
    chk("R5 inner x", cx, 4);
    emap = '0; set_pix(7, 7); set_pix(6, 6); wxl = 0; wxh = 5; wyl = 0; wyh = 7;
    run_pass("R5");
    chk("R5 outside window", votes, 0);

    // R2 start while busy is ignored, results hold
    emap = '1; full_win();
    keep = emap;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    emap = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(got);
    emap = keep;
    model_peak();
    chk("R2 busy start ignored", votes, ex_v);
    chk("R2 busy start x", cx, ex_x);
    dones = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk("R2 single done", dones, 0);
    chk("R2 held votes", votes, ex_v);
    chk("R2 held y", cy, ex_y);
    chk("R2 held radius", rad, ex_r);

    // R8 random maps and windows
    for (int t = 0; t < 40; t++) begin
      int lo, hi;
      emap = {$urandom, $urandom};
      if (t % 3 == 1) emap = emap & {$urandom, $urandom};
      if (t % 3 == 2) emap = emap | {$urandom, $urandom};
      if (t % 2 == 0) full_win();
      else begin
        lo = $urandom_range(0, 7); hi = $urandom_range(lo, 7);
        wxl = 3'(lo); wxh = 3'(hi);
        lo = $urandom_range(0, 7); hi = $urandom_range(lo, 7);
        wyl = 3'(lo); wyh = 3'(hi);
      end
      run_pass("R8 random");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule